// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for every beat of an SDRAM read or write burst. A mode word is captured from the address bus when the load strobe is high. It sets the burst length, the beat ordering, the latency value and whether writes are cut to one beat. A start pulse carries the first column and a read/write flag. From the next cycle on, the block presents one column per clock with a valid flag, and it raises a last flag on the final beat.

The block uses a three-state machine:
- `ST_IDLE`: no burst.
- `ST_RUN`: beats are being issued.
- `ST_STOP`: one final beat is issued after a terminate request.

The transitions are:
- IDLE→RUN on start.
- RUN→RUN on each further beat, or on a restart.
- RUN→IDLE after the last beat of a fixed-length burst.
- RUN→STOP when terminate is seen on a beat that is not the last.
- STOP→IDLE after that final beat.
- STOP→RUN on a start.

A full-page burst walks all 512 columns and wraps until it is terminated. The stored latency field is passed out for the command and data logic around the block.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `col_vld`, `col_last` and `cas_lat` are 0, and the mode is length 1, sequential, writes not shortened.
- R2: When `mode_ld` is high at a rising edge, `mode_word` is captured. Bits [6:4] then appear unchanged on `cas_lat` from the next cycle, and `cas_lat` holds while `mode_ld` is low.
- R3: Mode bits [2:0] set the burst length: 0→1, 1→2, 2→4, 3→8 and 7→full page. Codes 4, 5 and 6 act as length 1.
- R4: A `start` sampled at an edge makes the next cycle show `col_vld`=1 with `col_out`=`start_col`. One new beat follows per clock.
- R5: With mode bit 3 = 0 (sequential) and length L of 2, 4 or 8, beat i shows the start column with its low log2(L) bits replaced by (start low bits + i) mod L. The upper bits are kept.
- R6: With mode bit 3 = 1 (interleaved) and length L of 2, 4 or 8, beat i shows the start column with its low bits XORed with i.
- R7: A full-page burst outputs (start + i) mod 512 whatever bit 3 says, and never raises `col_last` unless terminated.
- R8: `col_last` is high exactly on the final beat of a fixed-length burst. In the next cycle `col_vld` is 0 unless a new start was sampled.
- R9: `term` sampled on a non-final beat produces exactly one more beat, flagged last, and then idle. `term` on a final beat or while idle has no effect.
- R10: A `start` sampled during a burst aborts it, and the next cycle shows beat 0 of the new burst. A start wins over a `term` at the same edge.
- R11: With mode bit 9 = 1, a start with `start_wr`=1 gives a single beat for any length, full page included. Reads keep the programmed length, and with bit 9 = 0 writes also use it.
- R12: A burst keeps the mode that was in force at its start. A mode load during the burst, or at the same edge as the start, does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_ld | input | 1 | Load `mode_word` into the mode register |
| mode_word | input | 12 | Mode key taken from the address bus |
| start | input | 1 | Begin a burst (restarts an active one) |
| start_col | input | 9 | First column of the burst |
| start_wr | input | 1 | 1 = write burst, 0 = read burst |
| term | input | 1 | Terminate the current burst |
| col_out | output | 9 | Column of the current beat |
| col_vld | output | 1 | A beat is presented this cycle |
| col_last | output | 1 | This beat is the final one |
| cas_lat | output | 3 | Stored latency field |

## Verification
Each length code, all eight included, is run from a start column whose low bits are not zero. This separates wrap-in-block from plain incrementing and shows whether the reserved codes fall back to one beat. Interleaved bursts start from an odd offset near the top of their block, where XOR and addition give different columns. The full-page case begins just below 511 with the interleave bit set, which exposes both the 512-column wrap and a wrong use of XOR ordering. Terminates, restarts, start-plus-terminate collisions, mode loads that coincide with starts, and write versus read starts in single-write mode test the priority and latching rules against a queue-based model on every clock.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2
    } bcg_state_t;

    // Bit positions inside the mode word
    localparam int MW_LEN_LSB  = 0;
    localparam int MW_LEN_W    = 3;
    localparam int MW_ILV_BIT  = 3;
    localparam int MW_LAT_LSB  = 4;
    localparam int MW_WSGL_BIT = 9;

    localparam logic [MW_LEN_W-1:0] LEN_PAGE = 3'd7;

endpackage

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg
    import burst_col_pkg::*;
#(
    parameter int MODE_W = 12,
    parameter int LAT_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld,
    input  logic [MODE_W-1:0]   word,
    output logic [MW_LEN_W-1:0] len_code,
    output logic                ilv,
    output logic [LAT_W-1:0]    lat,
    output logic                wr_single
);

    logic [MW_LEN_W-1:0] raw_len;
    logic [MW_LEN_W-1:0] len_d;

    assign raw_len = word[MW_LEN_LSB +: MW_LEN_W];

    // Reserved length codes collapse to a single beat
    always_comb begin
        if (raw_len <= 3'd3 || raw_len == LEN_PAGE) len_d = raw_len;
        else                                         len_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_code  <= '0;
            ilv       <= 1'b0;
            lat       <= '0;
            wr_single <= 1'b0;
        end else if (ld) begin
            len_code  <= len_d;
            ilv       <= word[MW_ILV_BIT];
            lat       <= word[MW_LAT_LSB +: LAT_W];
            wr_single <= word[MW_WSGL_BIT];
        end
    end

endmodule

// File: rtl/bcg_seq.sv
module bcg_seq
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [COL_W-1:0]    start_col,
    input  logic                start_wr,
    input  logic                term,
    input  logic [MW_LEN_W-1:0] len_code,
    input  logic                ilv_in,
    input  logic                wr_single,
    output logic [COL_W-1:0]    base,
    output logic [COL_W-1:0]    beat,
    output logic [COL_W-1:0]    mask,
    output logic                full,
    output logic                ilv,
    output logic                vld,
    output logic                last
);

    bcg_state_t       state_q, state_d;
    logic [COL_W-1:0] mask_d;
    logic             full_d;
    logic             one_beat;
    logic             final_beat;

    assign one_beat = wr_single && start_wr;

    always_comb begin
        unique case (len_code)
            3'd1:    mask_d = COL_W'(1);
            3'd2:    mask_d = COL_W'(3);
            3'd3:    mask_d = COL_W'(7);
            default: mask_d = '0;
        endcase
        if (one_beat) mask_d = '0;
        full_d = (len_code == LEN_PAGE) && !one_beat;
    end

    assign final_beat = !full && (beat == mask);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN: begin
                if (start)           state_d = ST_RUN;
                else if (final_beat) state_d = ST_IDLE;
                else if (term)       state_d = ST_STOP;
                else                 state_d = ST_RUN;
            end
            ST_STOP: state_d = start ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat    <= '0;
            base    <= '0;
            mask    <= '0;
            full    <= 1'b0;
            ilv     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                beat <= '0;
                base <= start_col;
                mask <= mask_d;
                full <= full_d;
                ilv  <= ilv_in;
            end else if (state_d != ST_IDLE) begin
                beat <= beat + 1'b1;
            end
        end
    end

    always_comb begin
        vld  = (state_q != ST_IDLE);
        last = (state_q == ST_STOP) || (state_q == ST_RUN && final_beat);
    end

    // R3
    beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !full) |-> (beat <= mask));

    // R9
    stop_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !start) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             full,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;

    always_comb begin
        low_seq = (base + beat) & mask;
        low_ilv = (base ^ beat) & mask;
        if (full)     col = base + beat;
        else if (ilv) col = (base & ~mask) | low_ilv;
        else          col = (base & ~mask) | low_seq;
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int MODE_W = 12,
    parameter int LAT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ld,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              start_wr,
    input  logic              term,
    output logic [COL_W-1:0]  col_out,
    output logic              col_vld,
    output logic              col_last,
    output logic [LAT_W-1:0]  cas_lat
);

    logic [MW_LEN_W-1:0] len_code;
    logic                mode_ilv;
    logic                wr_single;
    logic [COL_W-1:0]    base, beat, mask;
    logic                full, ilv;

    bcg_mode_reg #(.MODE_W(MODE_W), .LAT_W(LAT_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (mode_ld),
        .word      (mode_word),
        .len_code  (len_code),
        .ilv       (mode_ilv),
        .lat       (cas_lat),
        .wr_single (wr_single)
    );

    bcg_seq #(.COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_col (start_col),
        .start_wr  (start_wr),
        .term      (term),
        .len_code  (len_code),
        .ilv_in    (mode_ilv),
        .wr_single (wr_single),
        .base      (base),
        .beat      (beat),
        .mask      (mask),
        .full      (full),
        .ilv       (ilv),
        .vld       (col_vld),
        .last      (col_last)
    );

    bcg_col_map #(.COL_W(COL_W)) u_map (
        .base (base),
        .beat (beat),
        .mask (mask),
        .full (full),
        .ilv  (ilv),
        .col  (col_out)
    );

    // R4
    start_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col_vld && col_out == $past(start_col)));

    // R8
    last_has_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_vld);

    // R8
    idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !start) |=> !col_vld);

    // R9
    term_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld && !col_last && term && !start) |=> (col_vld && col_last));

    // R2
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ld |=> $stable(cas_lat));

endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;

    localparam int COL_W  = 9;
    localparam int MODE_W = 12;
    localparam int LAT_W  = 3;
    localparam int NCOL   = 1 << COL_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_ld = 1'b0;
    logic [MODE_W-1:0] mode_word = '0;
    logic              start = 1'b0;
    logic [COL_W-1:0]  start_col = '0;
    logic              start_wr = 1'b0;
    logic              term = 1'b0;
    logic [COL_W-1:0]  col_out;
    logic              col_vld;
    logic              col_last;
    logic [LAT_W-1:0]  cas_lat;

    always #5 clk = ~clk;

    burst_col_gen u_burst_col_gen (
        .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_word(mode_word),
        .start(start), .start_col(start_col), .start_wr(start_wr), .term(term),
        .col_out(col_out), .col_vld(col_vld), .col_last(col_last), .cas_lat(cas_lat)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // Reference model state
    int m_mode = 0;
    bit e_vld = 1'b0;
    bit e_last = 1'b0;
    int e_col = 0;
    int rest[$];
    bit pg = 1'b0;
    int pg_base = 0;
    int pg_idx = 0;
    int blen, off, blk;
    bit ilv_m;

    function automatic int len_of(int code);
        if (code <= 3) return 1 << code;
        if (code == 7) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; e_vld = 0; e_last = 0; pg = 0; rest.delete();
        end else begin
            if (start) begin
                blen  = len_of(m_mode & 7);
                ilv_m = ((m_mode >> 3) & 1) != 0;
                if ((((m_mode >> 9) & 1) != 0) && start_wr) blen = 1;
                rest.delete();
                e_vld = 1;
                if (blen == 0) begin
                    pg = 1; pg_base = int'(start_col); pg_idx = 0;
                    e_col = pg_base; e_last = 0;
                end else begin
                    pg  = 0;
                    off = int'(start_col) % blen;
                    blk = int'(start_col) - off;
                    for (int i = 0; i < blen; i++)
                        rest.push_back(blk + (ilv_m ? (off ^ i) : ((off + i) % blen)));
                    e_col  = rest.pop_front();
                    e_last = (rest.size() == 0);
                end
            end else if (e_vld) begin
                if (e_last) begin
                    e_vld = 0; e_last = 0;
                end else if (pg) begin
                    pg_idx++;
                    e_col  = (pg_base + pg_idx) % NCOL;
                    e_last = term;
                end else begin
                    e_col  = rest.pop_front();
                    e_last = (rest.size() == 0) || term;
                    if (term) rest.delete();
                end
            end
            if (mode_ld) m_mode = int'(mode_word);
        end
    end

    task automatic chk(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk(col_vld == e_vld, "col_vld", int'(col_vld), int'(e_vld));
            if (e_vld) begin
                chk(int'(col_out) == e_col, "col_out", int'(col_out), e_col);
                chk(col_last == e_last, "col_last", int'(col_last), int'(e_last));
            end else begin
                chk(col_last == 1'b0, "col_last idle", int'(col_last), 0);
            end
            chk(int'(cas_lat) == ((m_mode >> 4) & 7), "cas_lat", int'(cas_lat), (m_mode >> 4) & 7);
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_mode(int w);
        @(negedge clk); mode_ld = 1'b1; mode_word = MODE_W'(w);
        @(negedge clk); mode_ld = 1'b0;
    endtask

    task automatic go(int col, bit wr);
        @(negedge clk); start = 1'b1; start_col = COL_W'(col); start_wr = wr;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_term();
        @(negedge clk); term = 1'b1;
        @(negedge clk); term = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);

        // R2: latency field stored and held
        cur_req = "R2";
        load_mode('h020); wait_n(3);
        load_mode('h030); wait_n(3);

        // R4: first beat one cycle after start
        cur_req = "R4";
        load_mode('h033); go('h012, 0); wait_n(10);

        // R3: every length code, reserved ones included
        cur_req = "R3";
        for (int c = 0; c < 8; c++) begin
            load_mode('h030 | c);
            go('h0A5, 0);
            wait_n(10);
            if (c == 7) begin pulse_term(); wait_n(3); end
        end

        // R5: sequential wrap inside the aligned block
        cur_req = "R5";
        load_mode('h003); go('h1FD, 0); wait_n(10);
        load_mode('h002); go('h0F6, 1); wait_n(6);
        load_mode('h001); go('h0FF, 0); wait_n(4);

        // R6: interleaved ordering
        cur_req = "R6";
        for (int c = 1; c < 4; c++) begin
            load_mode('h008 | c); go('h16B, 0); wait_n(10);
        end

        // R7: full page, interleave bit ignored, wraps past 511
        cur_req = "R7";
        load_mode('h00F); go('h1FC, 0); wait_n(520);
        pulse_term(); wait_n(3);

        // R8: last flag then idle, back-to-back bursts
        cur_req = "R8";
        load_mode('h002); go('h041, 0); wait_n(6);
        go('h0C2, 0); wait_n(2); go('h0C6, 0); wait_n(6);

        // R9: terminate mid burst, on final beat, and while idle
        cur_req = "R9";
        load_mode('h003); go('h040, 0); wait_n(3); pulse_term(); wait_n(4);
        pulse_term(); wait_n(2);
        go('h040, 0); wait_n(6); pulse_term(); wait_n(4);

        // R10: restart and start-versus-terminate
        cur_req = "R10";
        go('h100, 0); wait_n(3); go('h1E7, 0); wait_n(3);
        @(negedge clk); start = 1'b1; term = 1'b1; start_col = 'h033; start_wr = 1'b0;
        @(negedge clk); start = 1'b0; term = 1'b0;
        wait_n(10);
        load_mode('h001); go('h010, 0); go('h021, 0); wait_n(4);

        // R11: single-beat writes
        cur_req = "R11";
        load_mode('h20B); go('h055, 1); wait_n(3); go('h055, 0); wait_n(10);
        load_mode('h00B); go('h055, 1); wait_n(10);
        load_mode('h207); go('h033, 1); wait_n(4);

        // R12: mode latched at start
        cur_req = "R12";
        load_mode('h003); go('h077, 0); wait_n(2); load_mode('h000); wait_n(10);
        @(negedge clk); mode_ld = 1'b1; mode_word = 'h003; start = 1'b1; start_col = 'h0E9; start_wr = 1'b0;
        @(negedge clk); mode_ld = 1'b0; start = 1'b0;
        wait_n(4);
        go('h0E9, 0); wait_n(10);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule